// File: doc/BRIEF.md
# Peripheral Bus Clock Scaler with Read Stall

This block derives a clock-enable for the slow peripheral bus from the fast system clock. A two-bit ratio field, taken from a fixed position in a wider oscillator control word, selects one enable pulse per 1, 2, 4 or 8 system cycles. Peripherals that run at the reduced rate advance only in cycles where the enable is high. Logic that always runs at the full system rate does not use this block.

When the CPU reads from the peripheral bus, the read completes only in a cycle that carries a peripheral enable. Until then the block stalls the CPU. The added latency therefore depends on where the divider stands when the request arrives. A new ratio waits for the current divider period to end before it takes effect, so an enable pulse is never cut short or repeated.

Top module: `pbscale_top`

## Requirements
- R1: The ratio field is bits 20:19 of `osc_ctrl`, with the encoding 00 = 1:1, 01 = 1:2, 10 = 1:4 and 11 = 1:8. All other bits of `osc_ctrl` have no effect.
- R2: While a ratio 1:P is in force, `pb_en` is high for exactly one cycle in every P system cycles.
- R3: In 1:1 mode, `pb_en` is high in every cycle, and a read completes in the same cycle it is requested, with no stall.
- R4: A read request completes (`rd_ready` high) only in a cycle where `pb_en` is high. If the divider phase is d (0..P-1) when the request is first presented and then held, the request stalls for P-1-d cycles. The stall is at most seven cycles, in 1:8 mode.
- R5: When `rd_req` is high, exactly one of `rd_ready` and `rd_stall` is high. When `rd_req` is low, both are low.
- R6: A ratio written to `osc_ctrl` takes effect only after the next `pb_en` cycle. The current period runs to its full length under the old ratio, and the next period has the new length.
- R7: A synchronous reset selects 1:1 and clears the phase. `pb_en` is high in the first cycle after reset. If a different ratio is in the field, the following period has that ratio's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_ctrl | input | 32 | Oscillator control word; ratio field at bits 20:19 |
| rd_req | input | 1 | CPU read request to the peripheral bus, held until ready |
| rd_ready | output | 1 | Read completes in this cycle |
| rd_stall | output | 1 | Read is held off this cycle |
| pb_en | output | 1 | Peripheral bus clock-enable pulse |

## Verification
Two functions can fall in the same cycle: a ratio change and the divider rollover. A read completion can also coincide with that same rollover. The bench writes a new ratio and presents a read in the very cycle that carries `pb_en`. It expects the read to complete under the old phase and the following period to have the new length. A second case writes the ratio mid-period. There the bench expects the remaining cycles of the old period to run unchanged before the new spacing appears.

// File: rtl/pbscale_pkg.sv
package pbscale_pkg;

    // Widest supported division is 2**MAX_SHIFT
    localparam int unsigned MAX_SHIFT = 3;
    localparam int unsigned RATIO_W   = 2;
    localparam int unsigned CNT_W     = MAX_SHIFT;

    typedef enum logic [RATIO_W-1:0] {
        PB_DIV1 = 2'd0,
        PB_DIV2 = 2'd1,
        PB_DIV4 = 2'd2,
        PB_DIV8 = 2'd3
    } pb_ratio_e;

    typedef struct packed {
        logic             roll;
        logic [CNT_W-1:0] phase;
    } phase_t;

    typedef struct packed {
        logic ready;
        logic stall;
    } rd_resp_t;

    // Last phase value of a period for the given ratio (period minus one)
    function automatic logic [CNT_W-1:0] ratio_term(pb_ratio_e r);
        logic [CNT_W:0] per;
        logic [CNT_W:0] lim;
        per = (CNT_W+1)'(1) << r;
        lim = per - (CNT_W+1)'(1);
        return lim[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/pbscale_ratio.sv
module pbscale_ratio
    import pbscale_pkg::*;
#(
    parameter int unsigned CTRL_W    = 32,
    parameter int unsigned FIELD_LSB = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              roll,
    output pb_ratio_e         act
);
    localparam int unsigned FIELD_MSB = FIELD_LSB + RATIO_W - 1;

    pb_ratio_e req;
    pb_ratio_e act_q;

    assign req = pb_ratio_e'(ctrl[FIELD_MSB:FIELD_LSB]);

    // New ratio is adopted only at the boundary of a period
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= PB_DIV1;
        end else if (roll) begin
            act_q <= req;
        end
    end

    assign act = act_q;

endmodule

// File: rtl/pbscale_phase.sv
module pbscale_phase
    import pbscale_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pb_ratio_e act,
    output phase_t    ph
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic             at_term;

    assign term    = ratio_term(act);
    assign at_term = (cnt_q == term);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (at_term) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign ph.roll  = at_term;
    assign ph.phase = cnt_q;

endmodule

// File: rtl/pbscale_rdgate.sv
module pbscale_rdgate
    import pbscale_pkg::*;
(
    input  logic     rd_req,
    input  logic     edge_now,
    output rd_resp_t resp
);
    // A read finishes only on a peripheral edge; otherwise it waits
    always_comb begin
        resp.ready = rd_req & edge_now;
        resp.stall = rd_req & ~edge_now;
    end

endmodule

// File: rtl/pbscale_top.sv
module pbscale_top
    import pbscale_pkg::*;
#(
    parameter int unsigned CTRL_W    = 32,
    parameter int unsigned FIELD_LSB = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] osc_ctrl,
    input  logic              rd_req,
    output logic              rd_ready,
    output logic              rd_stall,
    output logic              pb_en
);
    pb_ratio_e act_ratio;
    phase_t    ph;
    rd_resp_t  resp;

    pbscale_ratio #(
        .CTRL_W    (CTRL_W),
        .FIELD_LSB (FIELD_LSB)
    ) u_ratio (
        .clk  (clk),
        .rst  (rst),
        .ctrl (osc_ctrl),
        .roll (ph.roll),
        .act  (act_ratio)
    );

    pbscale_phase u_phase (
        .clk (clk),
        .rst (rst),
        .act (act_ratio),
        .ph  (ph)
    );

    pbscale_rdgate u_rdgate (
        .rd_req   (rd_req),
        .edge_now (ph.roll),
        .resp     (resp)
    );

    assign pb_en    = ph.roll;
    assign rd_ready = resp.ready;
    assign rd_stall = resp.stall;

endmodule

// File: rtl/pbscale_chk.sv
module pbscale_chk
    import pbscale_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      rd_req,
    input logic      rd_ready,
    input logic      rd_stall,
    input logic      pb_en,
    input pb_ratio_e act_ratio
);
    logic [CNT_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || pb_en) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + CNT_W'(1);
        end
    end

    // R2
    period_len_chk: assert property (@(posedge clk) disable iff (rst)
        pb_en |-> (gap_q == ratio_term(act_ratio)));

    // R2
    no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        !pb_en |-> (gap_q < ratio_term(act_ratio)));

    // R3
    div1_every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (act_ratio == PB_DIV1) |-> pb_en);

    // R4
    ready_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> pb_en);

    // R5
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_ready ^ rd_stall));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |-> (!rd_ready && !rd_stall));

    // R6
    switch_at_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (act_ratio != $past(act_ratio)) |-> $past(pb_en));

    // R7
    reset_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pb_en);

endmodule

bind pbscale_top pbscale_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .rd_ready  (rd_ready),
    .rd_stall  (rd_stall),
    .pb_en     (pb_en),
    .act_ratio (act_ratio)
);

// File: tb/pbscale_top_tb.sv
module pbscale_top_tb;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] osc_ctrl = 32'h0;
    logic        rd_req = 1'b0;
    logic        rd_ready;
    logic        rd_stall;
    logic        pb_en;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    pbscale_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .osc_ctrl (osc_ctrl),
        .rd_req   (rd_req),
        .rd_ready (rd_ready),
        .rd_stall (rd_stall),
        .pb_en    (pb_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Advance to the next cycle that carries an enable
    task automatic sync_en();
        for (int i = 0; i < 20; i++) begin
            step();
            if (pb_en) return;
        end
    endtask

    // From an enable cycle, count cycles to the next enable
    task automatic gap(output int g);
        g = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            g++;
            if (pb_en) return;
        end
    endtask

    function automatic logic [31:0] field(input int r, input logic [31:0] junk);
        return (junk & ~32'h0018_0000) | (32'(r) << 19);
    endfunction

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int g;
        int st;
        int p;
        repeat (3) step();
        rst = 1'b0;
        #1;
        // R7: enable in first cycle after reset
        chk(pb_en == 1'b1, "R7", int'(pb_en), 1);
        // R3: read in 1:1 needs no stall
        rd_req = 1'b1;
        #1;
        chk(rd_ready && !rd_stall, "R3", int'(rd_ready), 1);
        for (int i = 0; i < 4; i++) begin
            step();
            chk(pb_en && rd_ready, "R3", int'(pb_en), 1);
        end
        rd_req = 1'b0;

        // Sweep every ratio and every phase
        for (int r = 0; r < 4; r++) begin
            p = 1 << r;
            osc_ctrl = field(r, 32'hA5E7_3C96 ^ 32'(r * 32'h1111_0101));
            sync_en();
            sync_en();
            for (int k = 0; k < 3; k++) begin
                gap(g);
                // R2 / R1
                chk(g == p, "R2", g, p);
            end
            for (int d = 0; d < p; d++) begin
                sync_en();
                repeat (d + 1) step();
                rd_req = 1'b1;
                #1;
                st = 0;
                while (!rd_ready && st < 20) begin
                    chk(rd_stall == 1'b1, "R5", int'(rd_stall), 1);
                    step();
                    st++;
                end
                chk(rd_ready && !rd_stall, "R5", int'(rd_stall), 0);
                // R4: stall length equals the remaining phases
                chk(st == p - 1 - d, "R4", st, p - 1 - d);
                rd_req = 1'b0;
                #1;
                chk(!rd_ready && !rd_stall, "R5", int'(rd_ready | rd_stall), 0);
            end
        end

        // R6: mid-period change from 1:8 to 1:2
        osc_ctrl = field(3, 32'h0);
        sync_en();
        sync_en();
        repeat (4) step();
        osc_ctrl = field(1, 32'h0);
        g = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            g++;
            if (pb_en) break;
        end
        chk(g == 4, "R6", g, 4);
        gap(g);
        chk(g == 2, "R6", g, 2);

        // R6 with R4: change and read in the same enable cycle
        osc_ctrl = field(2, 32'h0);
        rd_req = 1'b1;
        #1;
        chk(rd_ready == 1'b1, "R4", int'(rd_ready), 1);
        step();
        rd_req = 1'b0;
        g = 1;
        while (!pb_en && g < 20) begin
            step();
            g++;
        end
        chk(g == 4, "R6", g, 4);

        // R7: reset mid-period with 1:4 still in the field
        repeat (2) step();
        rst = 1'b1;
        repeat (2) step();
        rst = 1'b0;
        #1;
        chk(pb_en == 1'b1, "R7", int'(pb_en), 1);
        gap(g);
        chk(g == 4, "R7", g, 4);

        // R1: only bits 20:19 matter
        osc_ctrl = 32'h0010_0000;
        sync_en();
        gap(g);
        chk(g == 4, "R1", g, 4);
        osc_ctrl = ~32'h0018_0000;
        sync_en();
        for (int i = 0; i < 3; i++) begin
            step();
            chk(pb_en == 1'b1, "R1", int'(pb_en), 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule